// File: doc/BRIEF.md
# Dual-Register Peripheral with Auxiliary Switch

This block is a register slave on a narrow I/O bus that carries a 4-bit module address and 4-bit data. It holds one peripheral module with two registers behind a single bus address. One is a primary register that plain reads and writes reach. The other is an auxiliary register. The block also contains the shared switch that redirects the module's next transfer to the auxiliary register. To use the switch, the bus master first writes the module's address, as data, to the switch address. The following transfer to the module then lands in the auxiliary register. When that transfer is complete, the switch disarms itself.

Each register is either a nibble or a byte wide, chosen by a parameter. A byte register is moved in two successive accesses to the module address, low nibble first and high nibble second. A nibble sequencer tracks which half is due. Byte writes are staged, and the whole byte is committed only when the high nibble arrives, so a half-written value is never visible.

The switch has two states: `SW_OFF` and `SW_ARMED`. `SW_ARMED` also stores the held address. A switch write moves the switch from `SW_OFF` to `SW_ARMED`. A switch write while armed reloads the held address. A consume moves `SW_ARMED` back to `SW_OFF`. The sequencer has three states: `SEQ_IDLE`, `SEQ_PRI_HI` and `SEQ_AUX_HI`. From `SEQ_IDLE`, a module access goes to `SEQ_AUX_HI` when the switch holds this module and the auxiliary register is a byte. Otherwise it goes to `SEQ_PRI_HI` for a byte primary register. When the register is a nibble wide, the sequencer stays in `SEQ_IDLE`. From either high state, the next module access returns the sequencer to `SEQ_IDLE`. Leaving `SEQ_AUX_HI` also consumes the switch.

Top module: `dual_reg_periph`

## Requirements
- R1: After reset, both registers read 0x00, the switch is off and the sequencer expects a low nibble.
- R2: `io_rdata` returns the selected nibble in the same cycle as a read strobe to the module address. It is 0 for every other address and whenever no read strobe to the module is present.
- R3: An access to the module address with the switch not holding this module goes to the primary register.
- R4: A write to the switch address (default 0xF) arms the switch with `io_wdata` as the held address. The next access to the module address (default 0x6) then goes to the auxiliary register, provided the held address equals the module address.
- R5: With the default byte-wide registers, consecutive accesses to a register alternate between the low nibble (bits 3:0) and the high nibble (bits 7:4), starting with the low nibble.
- R6: A low-nibble write leaves the visible byte unchanged. The high-nibble write commits {high, staged low} at once.
- R7: The switch disarms once the auxiliary transfer completes: after the second access with byte width, or after the only access with nibble width. Later accesses go to the primary register.
- R8: Accesses to other addresses, and reads of the switch address, neither consume nor clear an armed switch and do not advance the sequencer.
- R9: Writing the switch again before it is used replaces the held address. If the new address is not the module's, the module's next access goes to the primary register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_stb | input | 1 | Bus access strobe, one cycle per access |
| io_wr | input | 1 | 1 = write (OUT), 0 = read (IN) |
| io_addr | input | 4 | Module address |
| io_wdata | input | 4 | Write data nibble |
| io_rdata | output | 4 | Read data nibble, combinational |

## Verification
A read result is due in the same cycle as its strobe, so the bench drives each access on the falling edge and samples `io_rdata` 1 ns later, before the next rising edge. The effects of a write, a switch arming and a sequencer step take hold at the rising edge that ends the access. They therefore show up only in the read data of the next access, and the bench's reference model advances by exactly one step per strobe at that same edge. Directed sequences set out the fixed values for reset, staged byte writes, switch reload and switch survival across foreign accesses. A seeded random stream then compares every read against the model.

// File: rtl/dreg_pkg.sv
package dreg_pkg;
    localparam int NIB_W  = 4;
    localparam int ADDR_W = 4;

    typedef enum logic [1:0] {
        SEQ_IDLE   = 2'd0,
        SEQ_PRI_HI = 2'd1,
        SEQ_AUX_HI = 2'd2
    } seq_state_e;

    typedef enum logic {
        SW_OFF   = 1'b0,
        SW_ARMED = 1'b1
    } sw_state_e;
endpackage

// File: rtl/aux_switch.sv
module aux_switch
    import dreg_pkg::*;
#(
    parameter logic [ADDR_W-1:0] MOD_ADDR = 4'h6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm_i,
    input  logic [ADDR_W-1:0] arm_addr_i,
    input  logic              consume_i,
    output logic              hit_o
);
    sw_state_e         state_q, state_d;
    logic [ADDR_W-1:0] held_q, held_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SW_OFF;
            held_q  <= '0;
        end else begin
            state_q <= state_d;
            held_q  <= held_d;
        end
    end

    always_comb begin
        state_d = state_q;
        held_d  = held_q;
        unique case (state_q)
            SW_OFF: begin
                if (arm_i) begin
                    state_d = SW_ARMED;
                    held_d  = arm_addr_i;
                end
            end
            SW_ARMED: begin
                if (arm_i) begin
                    held_d = arm_addr_i;
                end else if (consume_i) begin
                    state_d = SW_OFF;
                    held_d  = '0;
                end
            end
            default: state_d = SW_OFF;
        endcase
    end

    always_comb begin
        hit_o = (state_q == SW_ARMED) && (held_q == MOD_ADDR);
    end

    // R4
    arm_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arm_i |=> (state_q == SW_ARMED) && (held_q == $past(arm_addr_i)));

    // R7
    consume_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (consume_i && !arm_i) |=> (state_q == SW_OFF) && !hit_o);

    // R8
    switch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!arm_i && !consume_i) |=> $stable(held_q) && $stable(state_q));
endmodule

// File: rtl/nibble_seq.sv
module nibble_seq
    import dreg_pkg::*;
#(
    parameter bit PRI_BYTE = 1'b1,
    parameter bit AUX_BYTE = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic acc_i,
    input  logic aux_hit_i,
    output logic sel_aux_o,
    output logic hi_o,
    output logic consume_o
);
    seq_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_IDLE: begin
                if (acc_i) begin
                    if (aux_hit_i) begin
                        if (AUX_BYTE) state_d = SEQ_AUX_HI;
                    end else if (PRI_BYTE) begin
                        state_d = SEQ_PRI_HI;
                    end
                end
            end
            SEQ_PRI_HI: if (acc_i) state_d = SEQ_IDLE;
            SEQ_AUX_HI: if (acc_i) state_d = SEQ_IDLE;
            default:    state_d = SEQ_IDLE;
        endcase
    end

    always_comb begin
        sel_aux_o = 1'b0;
        hi_o      = 1'b0;
        consume_o = 1'b0;
        unique case (state_q)
            SEQ_IDLE: begin
                sel_aux_o = aux_hit_i;
                consume_o = acc_i && aux_hit_i && !AUX_BYTE;
            end
            SEQ_PRI_HI: begin
                hi_o = 1'b1;
            end
            SEQ_AUX_HI: begin
                sel_aux_o = 1'b1;
                hi_o      = 1'b1;
                consume_o = acc_i;
            end
            default: ;
        endcase
    end

    // R5
    pri_hi_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEQ_PRI_HI && acc_i) |=> (state_q == SEQ_IDLE));

    // R8
    seq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_i |=> $stable(state_q));

    // R7
    consume_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        consume_o |=> (state_q == SEQ_IDLE));
endmodule

// File: rtl/reg_bank.sv
module reg_bank
    import dreg_pkg::*;
#(
    parameter int W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic             hi_i,
    input  logic [NIB_W-1:0] wdata_i,
    output logic [NIB_W-1:0] rdata_o
);
    logic [W-1:0] val_q;

    generate
        if (W > NIB_W) begin : g_byte
            logic [NIB_W-1:0] stage_q;

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    val_q   <= '0;
                    stage_q <= '0;
                end else if (wr_i) begin
                    if (!hi_i) stage_q <= wdata_i;
                    else       val_q   <= {wdata_i, stage_q};
                end
            end

            always_comb begin
                rdata_o = hi_i ? val_q[2*NIB_W-1:NIB_W] : val_q[NIB_W-1:0];
            end

            // R6
            low_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_i && !hi_i) |=> $stable(val_q));
        end else begin : g_nib
            logic unused_hi;

            always_ff @(posedge clk) begin
                if (!rst_n)    val_q <= '0;
                else if (wr_i) val_q <= wdata_i;
            end

            always_comb begin
                unused_hi = hi_i;
                rdata_o   = val_q;
            end
        end
    endgenerate

    initial begin
        width_ok_chk: assert (W == NIB_W || W == 2*NIB_W);
    end
endmodule

// File: rtl/dual_reg_periph.sv
module dual_reg_periph
    import dreg_pkg::*;
#(
    parameter logic [3:0] MOD_ADDR = 4'h6,
    parameter logic [3:0] SW_ADDR  = 4'hF,
    parameter int         PRI_W    = 8,
    parameter int         AUX_W    = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       io_stb,
    input  logic       io_wr,
    input  logic [3:0] io_addr,
    input  logic [3:0] io_wdata,
    output logic [3:0] io_rdata
);
    localparam bit PRI_BYTE = (PRI_W > NIB_W);
    localparam bit AUX_BYTE = (AUX_W > NIB_W);

    logic             mod_acc, sw_wr;
    logic             aux_hit, sel_aux, hi, consume;
    logic [NIB_W-1:0] pri_rd, aux_rd;

    always_comb begin
        mod_acc = io_stb && (io_addr == MOD_ADDR);
        sw_wr   = io_stb && io_wr && (io_addr == SW_ADDR);
    end

    aux_switch #(.MOD_ADDR(MOD_ADDR)) u_switch (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm_i     (sw_wr),
        .arm_addr_i(io_wdata),
        .consume_i (consume),
        .hit_o     (aux_hit)
    );

    nibble_seq #(.PRI_BYTE(PRI_BYTE), .AUX_BYTE(AUX_BYTE)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .acc_i    (mod_acc),
        .aux_hit_i(aux_hit),
        .sel_aux_o(sel_aux),
        .hi_o     (hi),
        .consume_o(consume)
    );

    reg_bank #(.W(PRI_W)) u_pri (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_i   (mod_acc && io_wr && !sel_aux),
        .hi_i   (hi),
        .wdata_i(io_wdata),
        .rdata_o(pri_rd)
    );

    reg_bank #(.W(AUX_W)) u_aux (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_i   (mod_acc && io_wr && sel_aux),
        .hi_i   (hi),
        .wdata_i(io_wdata),
        .rdata_o(aux_rd)
    );

    always_comb begin
        if (mod_acc && !io_wr) io_rdata = sel_aux ? aux_rd : pri_rd;
        else                   io_rdata = '0;
    end

    // R5
    aux_lo_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mod_acc && sel_aux && !hi && AUX_BYTE) |=> (hi && sel_aux));

    // R3
    pri_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mod_acc && !aux_hit && !hi) |-> !sel_aux);
endmodule

// File: tb/dual_reg_periph_tb.sv
`timescale 1ns/1ps
module dual_reg_periph_tb_top;
    localparam logic [3:0] MOD = 4'h6;
    localparam logic [3:0] SW  = 4'hF;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       io_stb = 1'b0, io_wr = 1'b0;
    logic [3:0] io_addr = '0, io_wdata = '0;
    logic [3:0] io_rdata;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    dual_reg_periph #(.MOD_ADDR(MOD), .SW_ADDR(SW)) dut_i (
        .clk(clk), .rst_n(rst_n), .io_stb(io_stb), .io_wr(io_wr),
        .io_addr(io_addr), .io_wdata(io_wdata), .io_rdata(io_rdata)
    );

    // Reference model of the requirements
    logic [7:0] m_pri, m_aux;
    logic [3:0] m_stg_p, m_stg_a, m_held;
    logic       m_armed;
    int         m_st;   // 0 low expected, 1 primary high, 2 auxiliary high

    function automatic logic m_sel_aux();
        return (m_st == 2) || (m_st == 0 && m_armed && m_held == MOD);
    endfunction

    function automatic logic [3:0] m_exp_rd(input logic [3:0] a);
        logic [7:0] v;
        if (a != MOD) return 4'h0;
        v = m_sel_aux() ? m_aux : m_pri;
        return (m_st != 0) ? v[7:4] : v[3:0];
    endfunction

    task automatic m_reset();
        m_pri = '0; m_aux = '0; m_stg_p = '0; m_stg_a = '0;
        m_held = '0; m_armed = 1'b0; m_st = 0;
    endtask

    task automatic m_step(input logic wr, input logic [3:0] a, input logic [3:0] d);
        logic sa, h;
        if (a == SW && wr) begin
            m_armed = 1'b1;
            m_held  = d;
        end else if (a == MOD) begin
            sa = m_sel_aux();
            h  = (m_st != 0);
            if (wr) begin
                if (sa) begin
                    if (!h) m_stg_a = d; else m_aux = {d, m_stg_a};
                end else begin
                    if (!h) m_stg_p = d; else m_pri = {d, m_stg_p};
                end
            end
            if (m_st == 0) m_st = sa ? 2 : 1;
            else begin
                if (m_st == 2) m_armed = 1'b0;
                m_st = 0;
            end
        end
    endtask

    task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: io_rdata actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // One bus access; a read is compared with the model and, if given, a fixed value
    task automatic acc(input logic wr, input logic [3:0] a, input logic [3:0] d,
                       input string tag, input int fixed);
        @(negedge clk);
        io_stb = 1'b1; io_wr = wr; io_addr = a; io_wdata = d;
        #1;
        if (!wr) begin
            check(tag, io_rdata, m_exp_rd(a));
            if (fixed >= 0) check(tag, io_rdata, fixed[3:0]);
        end
        m_step(wr, a, d);
        @(posedge clk);
        #1;
        io_stb = 1'b0; io_wr = 1'b0;
    endtask

    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        m_reset();
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R2 idle bus", io_rdata, 4'h0);

        // R1 reset values
        acc(1'b0, MOD, 4'h0, "R1 lo", 0);
        acc(1'b0, MOD, 4'h0, "R1 hi", 0);

        // R3 R5 primary byte write then read
        acc(1'b1, MOD, 4'hA, "R3", -1);
        acc(1'b1, MOD, 4'h5, "R3", -1);
        acc(1'b0, MOD, 4'h0, "R5 lo", 4'hA);
        acc(1'b0, MOD, 4'h0, "R5 hi", 4'h5);

        // R6 staged low nibble not visible
        acc(1'b1, MOD, 4'h1, "R6", -1);
        acc(1'b0, MOD, 4'h0, "R6 hi", 4'h5);
        acc(1'b0, MOD, 4'h0, "R6 lo", 4'hA);
        acc(1'b0, MOD, 4'h0, "R6 hi2", 4'h5);

        // R4 auxiliary byte write
        acc(1'b1, SW, MOD, "R4", -1);
        acc(1'b1, MOD, 4'h7, "R4", -1);
        acc(1'b1, MOD, 4'h2, "R4", -1);
        // R7 reverts to primary
        acc(1'b0, MOD, 4'h0, "R7 lo", 4'hA);
        acc(1'b0, MOD, 4'h0, "R7 hi", 4'h5);

        // R8 foreign accesses keep switch armed
        acc(1'b1, SW, MOD, "R8", -1);
        acc(1'b1, 4'h3, 4'h9, "R8", -1);
        acc(1'b0, SW, 4'h0, "R8 sw read", 0);
        acc(1'b0, 4'h2, 4'h0, "R2 other", 0);
        acc(1'b0, MOD, 4'h0, "R8 aux lo", 4'h7);
        acc(1'b0, MOD, 4'h0, "R8 aux hi", 4'h2);

        // R9 reload of the switch
        acc(1'b1, SW, MOD, "R9", -1);
        acc(1'b1, SW, 4'h2, "R9", -1);
        acc(1'b0, MOD, 4'h0, "R9 pri lo", 4'hA);
        acc(1'b0, MOD, 4'h0, "R9 pri hi", 4'h5);
        acc(1'b1, SW, 4'h2, "R9", -1);
        acc(1'b1, SW, MOD, "R9", -1);
        acc(1'b0, MOD, 4'h0, "R9 aux lo", 4'h7);
        acc(1'b0, MOD, 4'h0, "R9 aux hi", 4'h2);

        // Random traffic against the model (R2 R3 R4 R5 R6 R7 R8)
        for (int i = 0; i < 600; i++) begin
            int sel;
            logic [3:0] a, d;
            logic w;
            sel = int'($urandom % 8);
            d   = 4'($urandom);
            w   = 1'($urandom);
            if (sel < 3)      a = MOD;
            else if (sel < 5) begin
                a = SW;
                if ($urandom % 2 == 0) d = MOD;
            end else          a = 4'($urandom);
            if (($urandom % 5) == 0) begin
                @(negedge clk);
            end
            acc(w, a, d, "R2 random", -1);
        end

        @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule